// File: doc/BRIEF.md
# Framed Manchester Sample Transmitter

This block takes 16-bit converter samples from a parallel source and turns each one into a self-clocking serial line stream. It is meant to feed a differential line transceiver over long, cheap cabling. A remote receiver can recover both the clock and the data from a single pair. Every sample travels in a fixed frame. The frame opens with a long run of zero bits, so a receiver that has lost its place can always find the next start. A single one bit follows, and then the data word.

Each bit is sent as two half-bit symbols. The first half carries the inverse of the bit and the second half carries the bit itself, so every bit has a transition at its middle. The line output is taken directly from a register that only updates at half-bit boundaries, so it is free of glitches. A system-clock divider parameter sets the half-bit length, and with it the bit rate. A 50 MHz clock with 25 cycles per half gives 1 Mbit/s.

The source offers a word with `sample_valid`. The block pulses `sample_ready` for one system cycle at each frame boundary. A word is taken only if valid is high in that cycle. With no word on offer, the frame that follows carries only zero bits, with no start bit.

Top module: `manchester_frame_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `line_out` and `sample_ready` are both 0.
- R2: A frame lasts 48 bit times. Bit positions 0 to 30 of a frame carrying a sample are zero bits.
- R3: Bit position 31 of a frame carrying a sample is a one bit, even when the data word is 0x0000.
- R4: Bit positions 32 to 47 carry the accepted word, most significant bit first.
- R5: Each bit lasts 2 × HALF_DIV system cycles. `line_out` equals the inverse of the bit for the first HALF_DIV cycles and the bit for the next HALF_DIV cycles. It never changes inside a half.
- R6: `sample_ready` is high for exactly one system cycle per frame, and successive pulses are 96 × HALF_DIV cycles apart.
- R7: If `sample_valid` is low in the `sample_ready` cycle, all 48 bits of the following frame are zero bits.
- R8: A word is accepted only in the `sample_ready` cycle. Changes to `sample_data` or `sample_valid` at any other time do not alter the frame being sent. A valid pulse that does not cover the ready cycle yields an idle frame.
- R9: Frames follow each other with no gap. The last half of one frame is immediately followed by the first half of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_data | input | DATA_W | Parallel sample offered for transmission |
| sample_valid | input | 1 | Source has a sample on offer |
| sample_ready | output | 1 | One-cycle strobe at each frame boundary; a sample is taken when valid is also high |
| line_out | output | 1 | Registered Manchester line symbol |

## Verification
The busiest cycle is the frame boundary. There the final half symbol of one frame, the least significant data bit, is registered onto the line in the same cycle that the next word is loaded and `sample_ready` pulses. The bench keeps valid high with a new word across each boundary while the previous frame is still going out. It checks that the sample just after the boundary still shows the old word's last bit. It then checks that the following halves carry the new preamble, start bit and word. A valid pulse placed just before a boundary, and a word changed mid-frame, check that only the boundary cycle samples the inputs.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

   typedef enum logic {
      HALF_LEAD  = 1'b0,
      HALF_TRAIL = 1'b1
   } half_e;

   function automatic int frame_bits(input int pre_len, input int data_w);
      return pre_len + 1 + data_w;
   endfunction

endpackage

// File: rtl/mtx_half_tick.sv
module mtx_half_tick #(
   parameter int HALF_DIV = 25
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("mtx_half_tick: HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CNT_W = $clog2(HALF_DIV);
         localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

         logic [CNT_W-1:0] cnt_q;
         logic             wrap;

         assign wrap = (cnt_q == CNT_TOP);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (wrap) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = wrap;

         // R5: half periods longer than one cycle never tick twice in a row
         p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/mtx_frame_seq.sv
module mtx_frame_seq
   import mtx_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int PRE_LEN   = 31,
   parameter int FRAME_LEN = 48,
   parameter int IDX_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DATA_W-1:0] sample_data,
   input  logic              sample_valid,
   output logic              sample_ready,
   output logic              cur_bit,
   output logic              half_trail
);

   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] START_IDX = IDX_W'(PRE_LEN);

   logic [IDX_W-1:0]  idx_q;
   half_e             half_q;
   logic              active_q;
   logic [DATA_W-1:0] data_q;
   logic              at_end;
   logic              in_data;

   assign at_end  = (idx_q == LAST_IDX) && (half_q == HALF_TRAIL);
   assign in_data = (idx_q > START_IDX);

   always_comb begin
      if (idx_q < START_IDX) begin
         cur_bit = 1'b0;
      end else if (idx_q == START_IDX) begin
         cur_bit = active_q;
      end else begin
         cur_bit = data_q[DATA_W-1];
      end
   end

   assign half_trail   = (half_q == HALF_TRAIL);
   assign sample_ready = tick && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q    <= LAST_IDX;
         half_q   <= HALF_TRAIL;
         active_q <= 1'b0;
         data_q   <= '0;
      end else if (tick) begin
         if (at_end) begin
            idx_q    <= '0;
            half_q   <= HALF_LEAD;
            active_q <= sample_valid;
            data_q   <= sample_valid ? sample_data : '0;
         end else if (half_q == HALF_TRAIL) begin
            idx_q  <= idx_q + 1'b1;
            half_q <= HALF_LEAD;
            if (in_data) begin
               data_q <= {data_q[DATA_W-2:0], 1'b0};
            end
         end else begin
            half_q <= HALF_TRAIL;
         end
      end
   end

   // R6: the strobe marks the frame boundary and is never repeated at once
   p_frame_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_ready |=> (idx_q == '0 && half_q == HALF_LEAD));
   p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_ready |=> !sample_ready);

   // R7: an unclaimed boundary leaves an empty frame
   p_idle_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_ready && !sample_valid) |=> (!active_q && data_q == '0));

   // R8: the offered word is captured only at the strobe, frame state holds otherwise
   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_ready && sample_valid) |=> (active_q && data_q == $past(sample_data)));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(data_q) && $stable(active_q) && $stable(idx_q)));

endmodule

// File: rtl/mtx_line_enc.sv
module mtx_line_enc (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic cur_bit,
   input  logic half_trail,
   output logic line_q
);

   // leading half carries the inverted bit, trailing half the bit itself
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= 1'b0;
      end else if (tick) begin
         line_q <= cur_bit ^ ~half_trail;
      end
   end

endmodule

// File: rtl/manchester_frame_tx.sv
module manchester_frame_tx #(
   parameter int DATA_W   = 16,
   parameter int PRE_LEN  = 31,
   parameter int HALF_DIV = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] sample_data,
   input  logic              sample_valid,
   output logic              sample_ready,
   output logic              line_out
);

   localparam int FRAME_LEN = mtx_pkg::frame_bits(PRE_LEN, DATA_W);
   localparam int IDX_W     = $clog2(FRAME_LEN);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("manchester_frame_tx: DATA_W must be at least 2");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("manchester_frame_tx: PRE_LEN must be at least 1");
      end
   endgenerate

   logic tick;
   logic cur_bit;
   logic half_trail;

   mtx_half_tick #(
      .HALF_DIV (HALF_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   mtx_frame_seq #(
      .DATA_W    (DATA_W),
      .PRE_LEN   (PRE_LEN),
      .FRAME_LEN (FRAME_LEN),
      .IDX_W     (IDX_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .sample_data  (sample_data),
      .sample_valid (sample_valid),
      .sample_ready (sample_ready),
      .cur_bit      (cur_bit),
      .half_trail   (half_trail)
   );

   mtx_line_enc u_enc (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cur_bit    (cur_bit),
      .half_trail (half_trail),
      .line_q     (line_out)
   );

   // R5: the line only moves on the cycle after a half boundary
   p_line_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(line_out));

   // R6: a frame boundary is always a half boundary
   p_ready_on_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_ready |-> tick);

endmodule

// File: tb/manchester_frame_tx_bench.sv
module manchester_frame_tx_bench;

   localparam int DW     = 16;
   localparam int PRE    = 31;
   localparam int H      = 25;
   localparam int HALVES = 2 * (PRE + 1 + DW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] sample_data = '0;
   logic          sample_valid = 1'b0;
   logic          sample_ready;
   logic          line_out;

   int  checks = 0;
   int  failures = 0;
   bit  have_prev = 0;
   bit  prev_last = 0;
   bit  done = 0;

   always #10 clk = ~clk;

   manchester_frame_tx #(
      .DATA_W   (DW),
      .PRE_LEN  (PRE),
      .HALF_DIV (H)
   ) u_manchester_frame_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_data  (sample_data),
      .sample_valid (sample_valid),
      .sample_ready (sample_ready),
      .line_out     (line_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit frame_bit(input int k, input bit v, input logic [DW-1:0] d);
      if (!v || k < PRE) return 1'b0;
      if (k == PRE) return 1'b1;
      return d[DW-1-(k-PRE-1)];
   endfunction

   task automatic wait_ready();
      while (sample_ready !== 1'b1) @(negedge clk);
   endtask

   // R1
   task automatic t_reset();
      rst_n = 1'b0;
      sample_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 line in reset", line_out, 0);
      chk("R1 ready in reset", sample_ready, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 line after reset", line_out, 0);
      chk("R1 ready after reset", sample_ready, 0);
      have_prev = 0;
   endtask

   // R5 half width and R6 strobe spacing
   task automatic t_half_width();
      int n;
      sample_valid = 1'b0;
      wait_ready();
      n = 0;
      @(negedge clk); n++;
      chk("R6 ready one cycle", sample_ready, 0);
      repeat (H) begin @(negedge clk); n++; end
      chk("R5 leading half start", line_out, 1);
      for (int j = 1; j < H; j++) begin
         @(negedge clk); n++;
         chk("R5 leading half held", line_out, 1);
      end
      @(negedge clk); n++;
      chk("R5 trailing half", line_out, 0);
      while (sample_ready !== 1'b1) begin @(negedge clk); n++; end
      chk("R6 ready spacing", n, HALVES * H);
      have_prev = 0;
   endtask

   // one frame: offer d/v, optionally pulse valid before the boundary,
   // optionally alter the inputs after the boundary, then check every half
   task automatic run_frame(input logic [DW-1:0] d, input bit v,
                            input bit pulse_first, input bit change_mid,
                            input logic [DW-1:0] d_mid, input string tag_over);
      bit e;
      string tag;
      if (pulse_first) begin
         sample_data  = ~d;
         sample_valid = 1'b1;
         @(negedge clk);
      end
      sample_data  = d;
      sample_valid = v;
      wait_ready();
      @(negedge clk);
      chk("R6 ready dropped", sample_ready, 0);
      if (have_prev) chk("R9 previous frame last half", line_out, prev_last);
      if (change_mid) begin
         sample_data  = d_mid;
         sample_valid = ~v;
      end
      for (int k = 0; k < HALVES - 1; k++) begin
         repeat (H) @(negedge clk);
         e = frame_bit(k / 2, v, d);
         if (k % 2 == 0) e = ~e;
         if (tag_over != "") tag = tag_over;
         else if (!v) tag = "R7";
         else if (k / 2 < PRE) tag = "R2";
         else if (k / 2 == PRE) tag = "R3";
         else tag = "R4";
         chk($sformatf("%s half %0d", tag, k), line_out, e);
      end
      prev_last = frame_bit(PRE + DW, v, d);
      have_prev = 1;
      sample_valid = 1'b0;
   endtask

   initial begin
      t_reset();
      t_half_width();
      run_frame(16'h0000, 0, 0, 0, 16'h0000, "");      // R7 idle frame
      run_frame(16'hA5C3, 1, 0, 0, 16'h0000, "");      // R2 R3 R4
      run_frame(16'h8001, 1, 0, 1, 16'h7FFE, "R8");    // R8 mid-frame change ignored
      run_frame(16'hFFFF, 1, 0, 0, 16'h0000, "");      // R9 back to back
      run_frame(16'h0000, 1, 0, 0, 16'h0000, "");      // R3 start bit with zero word
      run_frame(16'h5A5A, 0, 1, 0, 16'h0000, "R8");    // R8 early valid pulse not taken
      run_frame(16'h1234, 1, 0, 0, 16'h0000, "");      // R4
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R6 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule